// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer sitting on a small 16-bit register bus. Software writes a timeout value and turns the counter on. From then on it has to keep the counter alive by writing a fixed two-word key to a service register. The counter steps down once for each pulse on a slow tick input, which nominally runs at 2 Hz. If the count runs out, the block drives a short reset pulse to the rest of the system. It also records the timeout in a status bit, and only a power-on reset clears that bit.

The timeout field is coded in half-second steps. A field value N allows N+1 ticks before expiry, so software writes 2·s−1 to get s seconds. This covers 0.5 s to 128 s. The enable bit and the low-power suspend bit can only be set; once set, software cannot clear them. A control bit can mask the reset output so that software can test the timeout path without resetting the system.

Top module: `wdog_keyed_timer`

## Requirements
- R1: After power-on reset, the control register and the status register both read 0x0000, and `wdog_rst` is low.
- R2: Registers sit at byte addresses 0x0 (control), 0x2 (service) and 0x4 (status). Control bits 15:8 hold the timeout field N, bit 3 is the reset mask, bit 2 is enable and bit 0 is suspend. The service address and any unmapped address read 0x0000. Status bit 1 is the timeout flag.
- R3: While the block is enabled, each tick pulse lowers the count by one. With field N loaded, the N+1-th tick expires the count and no earlier tick does. Ticks that arrive before enable have no effect.
- R4: On expiry with the mask bit clear, `wdog_rst` goes high in the clock cycle after the expiring tick and stays high for exactly 4 cycles.
- R5: A service write of 0x5555 followed by a service write of 0xAAAA reloads the count to N+1 ticks.
- R6: Any other service value, or 0xAAAA without a 0x5555 before it, causes no reload and clears the partial key.
- R7: Once enable is set, a control write with bit 2 clear does not clear it, and the count keeps running.
- R8: Once suspend is set it cannot be cleared. While suspend is set and `low_power` is high, ticks do not count. With suspend clear, `low_power` has no effect.
- R9: With the mask bit (bit 3) set, expiry does not raise `wdog_rst`, but it still sets the timeout flag.
- R10: The timeout flag is set on expiry and stays set through the reset pulse and through later activity. Only `por_n` clears it.
- R11: A new timeout field written while the block runs does not change the count in progress. It applies at the next reload.
- R12: The control write that first sets enable loads the count from the timeout field carried in that same write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 3 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick | input | 1 | Single-cycle count pulse (about 2 Hz) |
| low_power | input | 1 | Low-power mode indication |
| wdog_rst | output | 1 | System reset pulse on expiry |

## Verification
The service path is driven by a table of key pairs. These are the correct order, the reversed order, a wrong first word, a repeated first word and a near-miss second word. The count is placed one tick from expiry before each pair, so that a single following tick shows whether the pair reloaded the count. Directed cases then run the counter with a zero field and with fields loaded at enable. They also cover a field rewritten mid-count, suspend with the low-power input both high and low, and the reset mask. These cases separate counting, loading and suppression errors from errors in the pulse width and in the status latch.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W   = 16;
  localparam int FIELD_W = 8;
  localparam int ADDR_W  = 3;
  localparam int CNT_W   = FIELD_W + 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'h0;
  localparam logic [ADDR_W-1:0] ADR_SVC  = 3'h2;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'h4;

  localparam logic [REG_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_FIRE = 16'hAAAA;

  localparam int CB_SUSP   = 0;
  localparam int CB_EN     = 2;
  localparam int CB_MASK   = 3;
  localparam int FIELD_LSB = 8;
  localparam int SB_TOUT   = 1;

  typedef struct packed {
    logic [FIELD_W-1:0] field;
    logic               mask;
    logic               en;
    logic               susp;
  } ctrl_t;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [REG_W-1:0]   wdata,
  output ctrl_t              ctrl_q,
  output logic               first_en,
  output logic [FIELD_W-1:0] first_field
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.field = wdata[FIELD_LSB +: FIELD_W];
      ctrl_d.mask  = wdata[CB_MASK];
      ctrl_d.en    = ctrl_q.en   | wdata[CB_EN];
      ctrl_d.susp  = ctrl_q.susp | wdata[CB_SUSP];
    end
  end

  assign first_en    = ctrl_we & wdata[CB_EN] & ~ctrl_q.en;
  assign first_field = wdata[FIELD_LSB +: FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  p_en_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> ctrl_q.en);
  p_susp_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.susp |=> ctrl_q.susp);
  p_first_sets_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    first_en |=> ctrl_q.en);
endmodule

// File: rtl/wdog_key_check.sv
module wdog_key_check
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_we,
  input  logic [REG_W-1:0] wdata,
  output logic             reload
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (svc_we) armed_d = (wdata == KEY_ARM);
  end

  assign reload = svc_we & armed_q & (wdata == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  p_arm_on_first_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && wdata == KEY_ARM) |=> armed_q);
  p_disarm_on_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_we && wdata != KEY_ARM) |=> !armed_q);
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               first_load,
  input  logic [FIELD_W-1:0] first_field,
  input  logic               reload,
  input  logic [FIELD_W-1:0] field,
  input  logic               tick,
  input  logic               freeze,
  output logic               expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = en & tick & ~freeze;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (first_load) begin
      cnt_d = CNT_W'(first_field) + CNT_W'(1);
    end else if (!en) begin
      cnt_d = '0;
    end else if (reload) begin
      cnt_d = CNT_W'(field) + CNT_W'(1);
    end else if (step) begin
      if (cnt_q == CNT_W'(1)) begin
        expire = 1'b1;
        cnt_d  = CNT_W'(field) + CNT_W'(1);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_live_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt_q != '0);
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !freeze && !reload && !first_load && cnt_q > CNT_W'(1))
      |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && freeze && !reload && !first_load) |=> $stable(cnt_q));
  p_idle_no_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expire);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);
  localparam int PW = $clog2(LEN + 1);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)                 cnt_d = PW'(LEN);
    else if (cnt_q != '0)     cnt_d = cnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);

  p_fire_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse_o);
  p_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PW'(LEN));
endmodule

// File: rtl/wdog_keyed_timer.sv
module wdog_keyed_timer
  import wdog_pkg::*;
#(
  parameter int PULSE_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tick,
  input  logic              low_power,
  output logic              wdog_rst
);
  logic               rst_n;
  ctrl_t              ctrl_q;
  logic               ctrl_we, svc_we;
  logic               first_en, reload, expire, fire;
  logic [FIELD_W-1:0] first_field;
  logic               stat_q, stat_d;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(por_n), .rst_n(rst_n));

  assign ctrl_we = bus_we & (bus_addr == ADR_CTRL);
  assign svc_we  = bus_we & (bus_addr == ADR_SVC);

  wdog_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .first_en(first_en), .first_field(first_field));

  wdog_key_check u_key (
    .clk(clk), .rst_n(rst_n), .svc_we(svc_we), .wdata(bus_wdata),
    .reload(reload));

  wdog_down_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .first_load(first_en),
    .first_field(first_field), .reload(reload), .field(ctrl_q.field),
    .tick(tick), .freeze(ctrl_q.susp & low_power), .expire(expire));

  assign fire = expire & ~ctrl_q.mask;

  wdog_pulse #(.LEN(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse_o(wdog_rst));

  always_comb begin
    stat_d = stat_q | expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: begin
        bus_rdata[FIELD_LSB +: FIELD_W] = ctrl_q.field;
        bus_rdata[CB_MASK]              = ctrl_q.mask;
        bus_rdata[CB_EN]                = ctrl_q.en;
        bus_rdata[CB_SUSP]              = ctrl_q.susp;
      end
      ADR_STAT: bus_rdata[SB_TOUT] = stat_q;
      default:  bus_rdata = '0;
    endcase
  end

  p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |=> stat_q);
  p_pulse_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> stat_q);
  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.mask && !wdog_rst) |=> !wdog_rst);
endmodule

// File: tb/wdog_keyed_timer_tb.sv
`timescale 1ns/1ps
module wdog_keyed_timer_tb;
  logic        clk = 1'b0;
  logic        por_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        tick;
  logic        low_power;
  logic        wdog_rst;
  int          total = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  wdog_keyed_timer u_dut (
    .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .low_power(low_power), .wdog_rst(wdog_rst));

  // field, first key word, second key word, reload expected
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {8'd3, 16'h5555, 16'hAAAA, 1'b1},
    {8'd3, 16'hAAAA, 16'h5555, 1'b0},
    {8'd3, 16'h1234, 16'hAAAA, 1'b0},
    {8'd5, 16'h5555, 16'h5555, 1'b0},
    {8'd2, 16'h5555, 16'hAAAB, 1'b0},
    {8'd1, 16'h5555, 16'hAAAA, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    por_n = 1'b0; bus_we = 1'b0; tick = 1'b0; low_power = 1'b0;
    bus_addr = 3'h0; bus_wdata = 16'h0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse_tick();
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int n;
    por_n = 1'b0; bus_we = 1'b0; tick = 1'b0; low_power = 1'b0;
    bus_addr = 3'h0; bus_wdata = 16'h0;
    por();

    // R1 reset state
    rd(3'h0, r); check("R1 ctrl", r, 16'h0000);
    rd(3'h4, r); check("R1 status", r, 16'h0000);
    check("R1 rst", wdog_rst, 1'b0);

    // R5 / R6 key table
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  f;
      logic [15:0] k1, k2;
      logic        ok;
      {f, k1, k2, ok} = VEC[v];
      por();
      wr(3'h0, {f, 8'h04});
      ticks(int'(f));
      check("R3 no early expiry", wdog_rst, 1'b0);
      wr(3'h2, k1);
      wr(3'h2, k2);
      pulse_tick();
      check(ok ? "R5 key reloads" : "R6 bad key ignored", wdog_rst, !ok);
    end

    // R3 / R4 / R10 timeout and pulse length
    por();
    ticks(5);
    wr(3'h0, 16'h0204);
    ticks(2);
    check("R3 before expiry", wdog_rst, 1'b0);
    pulse_tick();
    check("R3 expiry on N+1 tick", wdog_rst, 1'b1);
    rd(3'h4, r); check("R10 flag set", r, 16'h0002);
    n = 0;
    while (wdog_rst && n < 20) begin n++; @(negedge clk); end
    check("R4 pulse length", n, 4);
    rd(3'h4, r); check("R10 flag held", r, 16'h0002);
    rd(3'h2, r); check("R2 service reads zero", r, 16'h0000);
    rd(3'h6, r); check("R2 unmapped reads zero", r, 16'h0000);
    por();
    rd(3'h4, r); check("R10 cleared by por", r, 16'h0000);

    // R3 zero field
    wr(3'h0, 16'h0004);
    pulse_tick();
    check("R3 field zero one tick", wdog_rst, 1'b1);

    // R7 enable sticky
    por();
    wr(3'h0, 16'h0105);
    rd(3'h0, r); check("R2 ctrl readback", r, 16'h0105);
    wr(3'h0, 16'h0100);
    rd(3'h0, r); check("R7 R8 bits stay set", r, 16'h0105);
    ticks(1);
    check("R7 still counting", wdog_rst, 1'b0);
    pulse_tick();
    check("R7 expires after clear attempt", wdog_rst, 1'b1);

    // R8 suspend freezes
    por();
    wr(3'h0, 16'h0305);
    low_power = 1'b1;
    ticks(10);
    check("R8 frozen", wdog_rst, 1'b0);
    low_power = 1'b0;
    ticks(3);
    check("R8 resumes", wdog_rst, 1'b0);
    pulse_tick();
    check("R8 expiry after resume", wdog_rst, 1'b1);
    por();
    wr(3'h0, 16'h0104);
    low_power = 1'b1;
    ticks(2);
    check("R8 no suspend bit", wdog_rst, 1'b1);
    low_power = 1'b0;

    // R9 mask
    por();
    wr(3'h0, 16'h010C);
    ticks(2);
    n = 0;
    repeat (6) begin if (wdog_rst) n++; @(negedge clk); end
    check("R9 masked output", n, 0);
    rd(3'h4, r); check("R9 flag still set", r, 16'h0002);

    // R11 field rewrite
    por();
    wr(3'h0, 16'h0204);
    wr(3'h0, 16'h0604);
    ticks(2);
    check("R11 old count runs", wdog_rst, 1'b0);
    pulse_tick();
    check("R11 old value expiry", wdog_rst, 1'b1);
    drain();
    wr(3'h2, 16'h5555);
    wr(3'h2, 16'hAAAA);
    ticks(6);
    check("R11 new value before", wdog_rst, 1'b0);
    pulse_tick();
    check("R11 new value expiry", wdog_rst, 1'b1);

    // R12 enable loads from same write
    por();
    wr(3'h0, 16'h0500);
    wr(3'h0, 16'h0104);
    pulse_tick();
    check("R12 first tick", wdog_rst, 1'b0);
    pulse_tick();
    check("R12 loads same-write field", wdog_rst, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule